// File: doc/BRIEF.md
# I2C Serial EEPROM Target (4 kbit)

This block is an I2C target that behaves like a 512-byte serial EEPROM. It samples the bus clock and data lines with the system clock and recognises START, repeated START and STOP conditions. It then decodes the select byte that opens every transfer. The device answers only when the type code and its two chip-enable bits match. One further bit of that byte chooses which 256-byte half of the array is addressed.

A write transfer sends one address byte and then data bytes. Each byte is acknowledged and stored at the running address. A read transfer streams bytes out from the running address for as long as the master acknowledges. When a transfer that stored data closes, a programming interval starts. During that interval every select byte is refused, so a master can poll for completion. The interval is doubled when the stored bytes touched more than one 8-byte row. All timing is counted in system clock cycles, derived from a clock-frequency parameter and a write-time parameter.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A select byte is acknowledged (SDA pulled low during the ninth clock) only when its bits 7..4 equal 1010 and its bits 3..2 equal `chip_sel[1:0]`. Otherwise SDA stays released for the rest of the transfer, including later bytes, until the next START.
- R2: Bit 1 of the select byte is the array address bit 8, so the same low address in the two halves reaches two different bytes.
- R3: Bit 0 of the select byte chooses the direction, with 0 for write. In a write, the byte after the select byte loads the low 8 address bits. Each later byte is acknowledged and stored at the running address, which then advances by one.
- R4: Bit 0 = 1 selects a read. The device sends the byte at the running address MSB first and advances the address after each byte. It continues while the master acknowledges, and it releases SDA for good after a missing acknowledge.
- R5: A STOP or a repeated START that ends a transfer which stored at least one byte starts a busy interval of WRITE_US microseconds at CLK_HZ. Every select byte decided within that interval is not acknowledged.
- R6: The busy interval is twice as long when the stored bytes do not all share address bits 8..3, meaning they lie in more than one 8-byte row.
- R7: A repeated START inside a transfer restarts select-byte decoding at once. This allows a write of the address followed by a read.
- R8: After reset, SDA is released and the first matching select byte is acknowledged.
- R9: The running address is 9 bits wide and wraps from 511 to 0, for both writes and reads.
- R10: The device changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pad |
| sda_in | input | 1 | Bus data line as seen on the pad (wired-AND result) |
| chip_sel | input | 2 | Chip-enable strap compared with select bits 3..2 |
| sda_pull | output | 1 | 1 = drive the data line low, 0 = release it |

## Verification
Two events can land on the same system-clock cycle. One is the close of a write transfer, which launches the programming timer. The other is the start of a new select decode. They coincide when a master follows its data bytes with a repeated START instead of a STOP. The bench provokes this by ending a row-spanning write with a repeated START and an immediate select byte. It judges the outcome at the acknowledge slot: the select must be refused. The written bytes must then read back correctly after the doubled interval.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK,
    PH_SEND,
    PH_MACK,
    PH_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    BY_SELECT,
    BY_ADDR,
    BY_DATA
  } byte_role_t;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
endpackage

// File: rtl/eep_line_sense.sv
module eep_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic scl_held,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_s, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign scl_held = scl_s & scl_d;
  assign start_ev = scl_held & sda_d & ~sda_s;
  assign stop_ev  = scl_held & ~sda_d & sda_s;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int TW = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic double_len,
  output logic busy
);
  localparam int W = $clog2(2 * TW + 1);
  localparam logic [W-1:0] LEN1 = W'(TW);
  localparam logic [W-1:0] LEN2 = W'(2 * TW);

  logic [W-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (launch)    cnt_d = double_len ? LEN2 : LEN1;
    else if (busy) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !launch) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int WRITE_US    = 10_000,
  parameter int BLOCK_BYTES = 256,
  parameter int ROW_BYTES   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] chip_sel,
  output logic       sda_pull
);
  import eep_pkg::*;

  localparam int LOW_W  = $clog2(BLOCK_BYTES);
  localparam int AW     = LOW_W + 1;
  localparam int DEPTH  = 2 * BLOCK_BYTES;
  localparam int RB     = $clog2(ROW_BYTES);
  localparam int TW     = (CLK_HZ / 1000) * WRITE_US / 1000;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  logic sda_lvl, scl_rise, scl_fall, scl_held, start_ev, stop_ev;
  eep_line_sense u_sense (
    .clk(clk), .rst_n(rst_n_s), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .scl_held(scl_held), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  phase_t         phase_q, phase_d;
  byte_role_t     role_q, role_d;
  logic [3:0]     cnt_q, cnt_d;
  logic [7:0]     shreg_q, shreg_d;
  logic [6:0]     txb_q, txb_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [AW-RB-1:0] row0_q, row0_d;
  logic           read_q, read_d, pull_q, pull_d, mack_q, mack_d;
  logic           wr_any_q, wr_any_d, span_q, span_d;
  logic           we, launch, busy, byte_done, sel_ok;
  logic [7:0]     rdata;

  eep_prog_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .launch(launch), .double_len(span_q), .busy(busy)
  );

  eep_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(we), .waddr(addr_q), .wdata(shreg_q),
    .raddr(addr_q), .rdata(rdata)
  );

  assign byte_done = (cnt_q == 4'd8);
  assign sel_ok    = (shreg_q[7:4] == TYPE_CODE) && (shreg_q[3:2] == chip_sel) && !busy;
  assign sda_pull  = pull_q;

  always_comb begin
    phase_d = phase_q; role_d = role_q; cnt_d = cnt_q; shreg_d = shreg_q;
    txb_d = txb_q; addr_d = addr_q; row0_d = row0_q; read_d = read_q;
    pull_d = pull_q; mack_d = mack_q; wr_any_d = wr_any_q; span_d = span_q;
    we = 1'b0; launch = 1'b0;
    if (start_ev) begin
      launch   = wr_any_q;
      wr_any_d = 1'b0;
      phase_d  = PH_RECV; role_d = BY_SELECT; cnt_d = '0; pull_d = 1'b0;
    end else if (stop_ev) begin
      launch   = wr_any_q;
      wr_any_d = 1'b0;
      phase_d  = PH_IDLE; pull_d = 1'b0;
    end else begin
      case (phase_q)
        PH_RECV: begin
          if (scl_rise && !byte_done) begin
            shreg_d = {shreg_q[6:0], sda_lvl};
            cnt_d   = cnt_q + 4'd1;
          end else if (scl_fall && byte_done) begin
            cnt_d = '0;
            case (role_q)
              BY_SELECT: begin
                if (sel_ok) begin
                  pull_d = 1'b1; phase_d = PH_ACK;
                  read_d = shreg_q[0];
                  addr_d[AW-1] = shreg_q[1];
                  role_d = BY_ADDR;
                end else begin
                  phase_d = PH_SKIP;
                end
              end
              BY_ADDR: begin
                addr_d[LOW_W-1:0] = shreg_q[LOW_W-1:0];
                pull_d = 1'b1; phase_d = PH_ACK; role_d = BY_DATA;
              end
              default: begin
                we = 1'b1;
                pull_d = 1'b1; phase_d = PH_ACK;
                addr_d = addr_q + AW'(1);
                wr_any_d = 1'b1;
                if (!wr_any_q) begin
                  row0_d = addr_q[AW-1:RB];
                  span_d = 1'b0;
                end else if (addr_q[AW-1:RB] != row0_q) begin
                  span_d = 1'b1;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (read_q) begin
              txb_d = rdata[6:0]; pull_d = ~rdata[7]; phase_d = PH_SEND;
            end else begin
              pull_d = 1'b0; phase_d = PH_RECV;
            end
          end
        end
        PH_SEND: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (byte_done) begin
              pull_d = 1'b0; phase_d = PH_MACK; addr_d = addr_q + AW'(1);
            end else begin
              pull_d = ~txb_q[6]; txb_d = {txb_q[5:0], 1'b0};
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_d = '0;
            if (mack_q) begin
              txb_d = rdata[6:0]; pull_d = ~rdata[7]; phase_d = PH_SEND;
            end else begin
              phase_d = PH_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      phase_q <= PH_IDLE; role_q <= BY_SELECT; cnt_q <= '0; shreg_q <= '0;
      txb_q <= '0; addr_q <= '0; row0_q <= '0; read_q <= 1'b0;
      pull_q <= 1'b0; mack_q <= 1'b0; wr_any_q <= 1'b0; span_q <= 1'b0;
    end else begin
      phase_q <= phase_d; role_q <= role_d; cnt_q <= cnt_d; shreg_q <= shreg_d;
      txb_q <= txb_d; addr_q <= addr_d; row0_q <= row0_d; read_q <= read_d;
      pull_q <= pull_d; mack_q <= mack_d; wr_any_q <= wr_any_d; span_q <= span_d;
    end
  end

  // R10
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    scl_held |-> $stable(pull_q));
  // R1
  miss_nack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_q == PH_RECV && role_q == BY_SELECT && scl_fall && byte_done &&
     !start_ev && !stop_ev && shreg_q[7:4] != TYPE_CODE) |=> (!pull_q && phase_q == PH_SKIP));
  // R1
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_q == PH_SKIP) |-> !pull_q);
  // R5
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_q == PH_RECV && role_q == BY_SELECT && scl_fall && byte_done &&
     !start_ev && !stop_ev && busy) |=> !pull_q);
  // R4
  mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_q == PH_MACK) |-> !pull_q);
endmodule

// File: tb/i2c_eeprom_target_test.sv
`timescale 1ns/1ps
module i2c_eeprom_target_test;
  localparam int Q  = 20;
  localparam int TW = 1000;
  localparam logic [7:0] SEL_W0 = 8'hA8;
  localparam logic [7:0] SEL_R0 = 8'hA9;
  localparam logic [7:0] SEL_W1 = 8'hAA;
  localparam logic [7:0] SEL_R1 = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic sda_line;
  int   checks = 0;
  int   failures = 0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_eeprom_target #(.CLK_HZ(50_000_000), .WRITE_US(20)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .chip_sel(2'b10), .sda_pull(sda_pull)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic i2c_rstart();
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wait_q();
    m_scl = 1'b1; wait_q();
    m_sda = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wait_q();
      m_scl = 1'b1; wait_q(); wait_q();
      m_scl = 1'b0; wait_q();
    end
    m_sda = 1'b1; wait_q();
    m_scl = 1'b1; wait_q();
    ack = ~sda_line; wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      m_scl = 1'b1; wait_q();
      b[i] = sda_line; wait_q();
      m_scl = 1'b0;
    end
    wait_q();
    m_sda = ~give_ack; wait_q();
    m_scl = 1'b1; wait_q(); wait_q();
    m_scl = 1'b0; wait_q();
  endtask

  // point the address with a write select, then read via repeated START
  task automatic set_addr_read(input logic blk, input logic [7:0] a);
    logic ack;
    i2c_start();
    send_byte(blk ? SEL_W1 : SEL_W0, ack);
    check(ack, "R3 addr select ack", ack, 1);
    send_byte(a, ack);
    i2c_rstart();
    send_byte(blk ? SEL_R1 : SEL_R0, ack);
    check(ack, "R7 read select after repeated START", ack, 1);
  endtask

  task automatic test_reset();
    check(sda_pull == 1'b0, "R8 SDA released after reset", sda_pull, 0);
  endtask

  task automatic test_select_filter();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hA0, ack);
    check(!ack, "R1 chip bits mismatch not acked", ack, 0);
    send_byte(SEL_W0, ack);
    check(!ack, "R1 ignored until next START", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hB8, ack);
    check(!ack, "R1 type code mismatch not acked", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(SEL_R0, ack);
    check(ack, "R8 first matching select acked", ack, 1);
    recv_byte(1'b0, b);
    i2c_stop();
  endtask

  task automatic test_write_read();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(SEL_W0, ack);
    send_byte(8'h10, ack);
    check(ack, "R3 address byte acked", ack, 1);
    send_byte(8'h11, ack);
    check(ack, "R3 data byte acked", ack, 1);
    send_byte(8'h22, ack);
    send_byte(8'h33, ack);
    i2c_stop();
    i2c_start();
    send_byte(SEL_W0, ack);
    check(!ack, "R5 select refused while busy", ack, 0);
    i2c_stop();
    wait_cyc(2 * TW);
    set_addr_read(1'b0, 8'h10);
    recv_byte(1'b1, b);
    check(b == 8'h11, "R4 read byte 0", b, 8'h11);
    recv_byte(1'b1, b);
    check(b == 8'h22, "R4 read byte 1", b, 8'h22);
    recv_byte(1'b0, b);
    check(b == 8'h33, "R3 read byte 2", b, 8'h33);
    check(sda_pull == 1'b0, "R4 SDA released after no-ack", sda_pull, 0);
    wait_q();
    check(sda_pull == 1'b0, "R4 SDA stays released", sda_pull, 0);
    i2c_stop();
  endtask

  task automatic test_block();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(SEL_W1, ack);
    send_byte(8'h10, ack);
    send_byte(8'h5A, ack);
    i2c_stop();
    wait_cyc(2 * TW + 200);
    set_addr_read(1'b0, 8'h10);
    recv_byte(1'b0, b);
    i2c_stop();
    check(b == 8'h11, "R2 block 0 untouched", b, 8'h11);
    set_addr_read(1'b1, 8'h10);
    recv_byte(1'b0, b);
    i2c_stop();
    check(b == 8'h5A, "R2 block 1 holds its byte", b, 8'h5A);
  endtask

  task automatic test_timing();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(SEL_W0, ack);
    send_byte(8'h20, ack);
    send_byte(8'hC1, ack);
    send_byte(8'hC2, ack);
    i2c_stop();
    wait_cyc(500);
    i2c_start();
    send_byte(SEL_W0, ack);
    check(ack, "R5 single-row interval over", ack, 1);
    i2c_stop();
    i2c_start();
    send_byte(SEL_W0, ack);
    send_byte(8'h06, ack);
    send_byte(8'hD6, ack);
    send_byte(8'hD7, ack);
    send_byte(8'hD8, ack);
    i2c_stop();
    wait_cyc(500);
    i2c_start();
    send_byte(SEL_W0, ack);
    check(!ack, "R6 two-row interval still busy", ack, 0);
    i2c_stop();
    wait_cyc(1000);
    i2c_start();
    send_byte(SEL_W0, ack);
    check(ack, "R6 two-row interval over", ack, 1);
    i2c_stop();
    set_addr_read(1'b0, 8'h06);
    recv_byte(1'b1, b);
    check(b == 8'hD6, "R3 row-crossing byte 0", b, 8'hD6);
    recv_byte(1'b1, b);
    recv_byte(1'b0, b);
    check(b == 8'hD8, "R3 row-crossing byte 2", b, 8'hD8);
    i2c_stop();
  endtask

  task automatic test_wrap_rstart();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(SEL_W1, ack);
    send_byte(8'hFF, ack);
    send_byte(8'h77, ack);
    send_byte(8'h88, ack);
    i2c_rstart();
    send_byte(SEL_W0, ack);
    check(!ack, "R5 repeated START after write refuses select", ack, 0);
    i2c_stop();
    wait_cyc(2 * TW + 200);
    set_addr_read(1'b1, 8'hFF);
    recv_byte(1'b1, b);
    check(b == 8'h77, "R9 byte at 511", b, 8'h77);
    recv_byte(1'b0, b);
    check(b == 8'h88, "R9 read wraps to 0", b, 8'h88);
    i2c_stop();
    set_addr_read(1'b0, 8'h00);
    recv_byte(1'b0, b);
    check(b == 8'h88, "R9 write wrapped to 0", b, 8'h88);
    i2c_stop();
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(10);
    test_reset();
    test_select_filter();
    test_write_read();
    test_block();
    test_timing();
    test_wrap_rstart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule